// File: doc/BRIEF.md
# UART Reference Clock Divider with Segmented Divisor Fields

This block derives a UART reference clock from a fast system clock. The divided path divides by an integer n from 7 to 44. Three configuration fields set n, and each field covers its own sub-range with its own offset. When all three fields are zero, n falls back to 44. A source selector then routes one of three clocks to the reference output: the divided fast clock, a peripheral clock, or an external clock pin.

The divided path runs from a counter that wraps at n−1. For odd n the high phase is one fast-clock cycle longer than the low phase. Alongside the clock, the block produces a single-cycle tick in the fast-clock domain, meant for downstream baud logic. A new divisor is adopted only when the counter wraps, so a period is never cut short. If more than one field is non-zero, the block raises an error flag and resolves the conflict by a fixed priority.

Top module: `uart_refclk_div`

## Requirements
- R1: With `div_lo` = v (1..15) and the other two fields zero, the divided period is v + 6 fast-clock cycles (7..21).
- R2: With `div_mid` = v (1..15) and the other two fields zero, the divided period is v + 21 cycles (22..36).
- R3: With `div_hi` = v (1..7) and the other two fields zero, the divided period is v + 36 cycles (37..43).
- R4: With all three fields zero, the divided period is 44 cycles.
- R5: `cfg_err` is 1 while two or more fields are non-zero, and 0 otherwise. In that case the divisor follows the first non-zero field in the order `div_lo`, `div_mid`, `div_hi`.
- R6: When enabled, the divided clock has period n. Each period starts with a high phase of (n+1)/2 cycles (rounded down), followed by the low phase.
- R7: `ref_tick` pulses high for exactly one fast-clock cycle per divided period, in the last cycle of the period. The high phase of the next period starts in the following cycle.
- R8: A change to the divider fields does not alter the period in progress. The new divisor takes effect from the next period.
- R9: While `div_en` is 0, the divided clock is low, `ref_tick` is 0 and the counter is held at zero. After `div_en` rises, the first `ref_tick` comes in the n-th cycle, counting the cycle in which `div_en` is first seen high.
- R10: `src_sel` encoding: 2'b00 selects `clk_periph`, 2'b01 selects the divided fast clock, and 2'b10 or 2'b11 selects `clk_ext`. `ref_tick` is 0 unless 2'b01 is selected.
- R11: After reset, with the divided source selected, `ref_clk` and `ref_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast system clock feeding the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_periph | input | 1 | Peripheral clock source |
| clk_ext | input | 1 | External clock source |
| div_lo | input | 4 | Low-range divisor field (offset 6) |
| div_mid | input | 4 | Middle-range divisor field (offset 21) |
| div_hi | input | 3 | High-range divisor field (offset 36) |
| div_en | input | 1 | Enable for the divided fast clock |
| src_sel | input | 2 | Reference source select |
| ref_clk | output | 1 | Selected reference clock |
| ref_tick | output | 1 | One-cycle strobe per divided period (fast-clock domain) |
| cfg_err | output | 1 | More than one divisor field is non-zero |

## Verification
On every cycle, the assertions check the following:
- the counter stays below the latched divisor;
- the counter returns to zero after each tick, and the high phase starts right after it;
- the latched divisor holds steady between wraps;
- the output is held low and the counter at zero while disabled;
- no tick appears on a non-divided source.

Only the bench's scenarios can show that each field produces the right divisor with its offset and that priority resolves conflicts. The same holds for measuring the high/low split for odd and even n, for a mid-period field change holding until the wrap, and for the routing of the two foreign clocks.

// File: rtl/uart_refclk_pkg.sv
package uart_refclk_pkg;
  localparam int LO_W      = 4;
  localparam int MID_W     = 4;
  localparam int HI_W      = 3;
  localparam int LO_OFS    = 6;
  localparam int MID_OFS   = 21;
  localparam int HI_OFS    = 36;
  localparam int N_ALLZERO = 44;
  localparam int CNT_W     = $clog2(N_ALLZERO + 2);

  typedef enum logic [1:0] {
    SRC_PERIPH  = 2'b00,
    SRC_DIV     = 2'b01,
    SRC_EXT     = 2'b10,
    SRC_EXT_ALT = 2'b11
  } src_e;
endpackage

// File: rtl/urd_decode.sv
module urd_decode #(
  parameter int LO_W      = 4,
  parameter int MID_W     = 4,
  parameter int HI_W      = 3,
  parameter int LO_OFS    = 6,
  parameter int MID_OFS   = 21,
  parameter int HI_OFS    = 36,
  parameter int N_ALLZERO = 44,
  parameter int CNT_W     = 6
) (
  input  logic [LO_W-1:0]  lo_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [HI_W-1:0]  hi_i,
  output logic [CNT_W-1:0] n_o,
  output logic             err_o
);
  logic lo_nz, mid_nz, hi_nz;

  always_comb begin
    lo_nz  = |lo_i;
    mid_nz = |mid_i;
    hi_nz  = |hi_i;
    err_o  = (lo_nz & mid_nz) | (lo_nz & hi_nz) | (mid_nz & hi_nz);
    if (lo_nz) begin
      n_o = CNT_W'(lo_i) + CNT_W'(LO_OFS);
    end else if (mid_nz) begin
      n_o = CNT_W'(mid_i) + CNT_W'(MID_OFS);
    end else if (hi_nz) begin
      n_o = CNT_W'(hi_i) + CNT_W'(HI_OFS);
    end else begin
      n_o = CNT_W'(N_ALLZERO);
    end
  end
endmodule

// File: rtl/urd_core.sv
module urd_core #(
  parameter int CNT_W     = 6,
  parameter int N_ALLZERO = 44,
  parameter int N_MIN     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             div_clk_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] n_q, n_d;
  logic             clk_q, clk_d;
  logic             wrap;
  logic [CNT_W-1:0] half_d;

  // next-state
  always_comb begin
    wrap = (cnt_q == (n_q - CNT_W'(1)));
    if (!en_i) begin
      cnt_d = '0;
      n_d   = n_i;
    end else if (wrap) begin
      cnt_d = '0;
      n_d   = n_i;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      n_d   = n_q;
    end
    half_d = (n_d + CNT_W'(1)) >> 1;
    clk_d  = en_i & (cnt_d < half_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= CNT_W'(N_ALLZERO);
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
      clk_q <= clk_d;
    end
  end

  assign div_clk_o = clk_q;
  assign tick_o    = en_i & wrap;

  // R6: counter never reaches the latched divisor
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_q);
  // R4: latched divisor stays within the legal span
  a_r4_n_range: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= CNT_W'(N_MIN)) && (n_q <= CNT_W'(N_ALLZERO)));
  // R7: after a tick the count restarts and the high phase begins
  a_r7_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0) && clk_q);
  // R8: divisor only changes at a wrap or while disabled
  a_r8_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_o) |=> $stable(n_q));
  // R9: disabled means low output and zero count
  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !clk_q);
endmodule

// File: rtl/urd_srcmux.sv
module urd_srcmux
  import uart_refclk_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       periph_i,
  input  logic       div_i,
  input  logic       ext_i,
  output logic       clk_o
);
  always_comb begin
    case (src_e'(sel_i))
      SRC_PERIPH: clk_o = periph_i;
      SRC_DIV:    clk_o = div_i;
      default:    clk_o = ext_i;
    endcase
  end
endmodule

// File: rtl/uart_refclk_div.sv
module uart_refclk_div
  import uart_refclk_pkg::*;
#(
  parameter int P_LO_W      = LO_W,
  parameter int P_MID_W     = MID_W,
  parameter int P_HI_W      = HI_W,
  parameter int P_LO_OFS    = LO_OFS,
  parameter int P_MID_OFS   = MID_OFS,
  parameter int P_HI_OFS    = HI_OFS,
  parameter int P_N_ALLZERO = N_ALLZERO
) (
  input  logic               clk_fast,
  input  logic               rst_n,
  input  logic               clk_periph,
  input  logic               clk_ext,
  input  logic [P_LO_W-1:0]  div_lo,
  input  logic [P_MID_W-1:0] div_mid,
  input  logic [P_HI_W-1:0]  div_hi,
  input  logic               div_en,
  input  logic [1:0]         src_sel,
  output logic               ref_clk,
  output logic               ref_tick,
  output logic               cfg_err
);
  localparam int P_CNT_W = $clog2(P_N_ALLZERO + 2);
  localparam int P_N_MIN = P_LO_OFS + 1;

  logic             rst_s1_q, rst_s2_q;
  logic             rst_int_n;
  logic [P_CNT_W-1:0] n_dec;
  logic             div_clk;
  logic             div_tick;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  urd_decode #(
    .LO_W(P_LO_W), .MID_W(P_MID_W), .HI_W(P_HI_W),
    .LO_OFS(P_LO_OFS), .MID_OFS(P_MID_OFS), .HI_OFS(P_HI_OFS),
    .N_ALLZERO(P_N_ALLZERO), .CNT_W(P_CNT_W)
  ) u_decode (
    .lo_i(div_lo), .mid_i(div_mid), .hi_i(div_hi),
    .n_o(n_dec), .err_o(cfg_err)
  );

  urd_core #(
    .CNT_W(P_CNT_W), .N_ALLZERO(P_N_ALLZERO), .N_MIN(P_N_MIN)
  ) u_core (
    .clk(clk_fast), .rst_n(rst_int_n), .en_i(div_en), .n_i(n_dec),
    .div_clk_o(div_clk), .tick_o(div_tick)
  );

  urd_srcmux u_mux (
    .sel_i(src_sel), .periph_i(clk_periph), .div_i(div_clk),
    .ext_i(clk_ext), .clk_o(ref_clk)
  );

  assign ref_tick = div_tick & (src_sel == SRC_DIV);

  // R10: tick only accompanies the divided source
  a_r10_tick_src: assert property (@(posedge clk_fast) disable iff (!rst_int_n)
    ref_tick |-> (src_sel == 2'b01));
endmodule

// File: tb/uart_refclk_div_tb.sv
`timescale 1ns/1ps
module uart_refclk_div_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic clk_periph = 1'b0;
  logic clk_ext = 1'b0;
  logic [3:0] div_lo;
  logic [3:0] div_mid;
  logic [2:0] div_hi;
  logic div_en;
  logic [1:0] src_sel;
  logic ref_clk, ref_tick, cfg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  int m_cnt, m_n;
  bit m_out;

  always #4 clk = ~clk;
  initial begin #3; forever #6 clk_periph = ~clk_periph; end
  initial begin #2.5; forever #5 clk_ext = ~clk_ext; end

  uart_refclk_div u_dut (
    .clk_fast(clk), .rst_n(rst_n), .clk_periph(clk_periph), .clk_ext(clk_ext),
    .div_lo(div_lo), .div_mid(div_mid), .div_hi(div_hi), .div_en(div_en),
    .src_sel(src_sel), .ref_clk(ref_clk), .ref_tick(ref_tick), .cfg_err(cfg_err)
  );

  function automatic int exp_div(int lo, int mid, int hi);
    if (lo != 0) return lo + 6;
    if (mid != 0) return mid + 21;
    if (hi != 0) return hi + 36;
    return 44;
  endfunction

  function automatic bit exp_err(int lo, int mid, int hi);
    return (int'(lo != 0) + int'(mid != 0) + int'(hi != 0)) > 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_n = 44; m_out = 1'b0;
    end else if (!div_en) begin
      m_cnt = 0; m_n = exp_div(div_lo, div_mid, div_hi); m_out = 1'b0;
    end else begin
      if (m_cnt == m_n - 1) begin
        m_cnt = 0; m_n = exp_div(div_lo, div_mid, div_hi);
      end else begin
        m_cnt++;
      end
      m_out = (m_cnt < (m_n + 1) / 2);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      bit et;
      et = div_en && (m_cnt == m_n - 1) && (src_sel == 2'b01);
      if (src_sel == 2'b01) check(ref_clk == m_out, "R6 model clk", int'(ref_clk), int'(m_out));
      check(ref_tick == et, "R7 model tick", int'(ref_tick), int'(et));
      check(cfg_err == exp_err(div_lo, div_mid, div_hi), "R5 model err",
            int'(cfg_err), int'(exp_err(div_lo, div_mid, div_hi)));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic set_fields(int lo, int mid, int hi);
    @(posedge clk); #1;
    div_lo = 4'(lo); div_mid = 4'(mid); div_hi = 3'(hi);
  endtask

  // waits for a tick, then measures one full period and its high count
  task automatic measure(int n, string req);
    int len, hi;
    do @(negedge clk); while (!ref_tick);
    len = 0; hi = 0;
    do begin
      @(negedge clk);
      len++;
      if (ref_clk) hi++;
    end while (!ref_tick);
    check(len == n, {req, " period"}, len, n);
    check(hi == (n + 1) / 2, {req, " R6 high"}, hi, (n + 1) / 2);
  endtask

  initial begin
    rst_n = 1'b0; div_lo = '0; div_mid = '0; div_hi = '0;
    div_en = 1'b0; src_sel = 2'b01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ref_clk == 1'b0, "R11 reset clk", int'(ref_clk), 0);
    check(ref_tick == 1'b0, "R11 reset tick", int'(ref_tick), 0);
    check(cfg_err == 1'b0, "R11 reset err", int'(cfg_err), 0);
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;

    // R9: enable latency from idle, divisor 44 (R4)
    begin
      int len;
      @(posedge clk); #1 div_en = 1'b1;
      len = 0;
      do begin @(negedge clk); len++; end while (!ref_tick);
      check(len == 44, "R9 first tick", len, 44);
    end
    measure(44, "R4 all-zero");

    set_fields(1, 0, 0);  measure(7, "R1 lo=1");  measure(7, "R1 lo=1");
    set_fields(8, 0, 0);  measure(14, "R1 lo=8"); measure(14, "R1 lo=8");
    set_fields(15, 0, 0); measure(21, "R1 lo=15"); measure(21, "R1 lo=15");
    set_fields(0, 1, 0);  measure(22, "R2 mid=1"); measure(22, "R2 mid=1");
    set_fields(0, 15, 0); measure(36, "R2 mid=15"); measure(36, "R2 mid=15");
    set_fields(0, 0, 1);  measure(37, "R3 hi=1");  measure(37, "R3 hi=1");
    set_fields(0, 0, 7);  measure(43, "R3 hi=7");  measure(43, "R3 hi=7");

    // R5: conflicts
    set_fields(3, 5, 0);
    @(negedge clk); check(cfg_err == 1'b1, "R5 lo+mid err", int'(cfg_err), 1);
    measure(9, "R5 lo+mid"); measure(9, "R5 lo+mid");
    set_fields(0, 2, 4);
    @(negedge clk); check(cfg_err == 1'b1, "R5 mid+hi err", int'(cfg_err), 1);
    measure(23, "R5 mid+hi"); measure(23, "R5 mid+hi");
    set_fields(2, 9, 6);
    @(negedge clk); check(cfg_err == 1'b1, "R5 all err", int'(cfg_err), 1);
    measure(8, "R5 all"); measure(8, "R5 all");
    set_fields(0, 0, 5);
    @(negedge clk); check(cfg_err == 1'b0, "R5 single clear", int'(cfg_err), 0);
    measure(41, "R3 hi=5"); measure(41, "R3 hi=5");

    // R8: change right after a wrap; current period keeps the old divisor
    begin
      int len;
      do @(negedge clk); while (!ref_tick);
      @(posedge clk); #1 div_lo = 4'd4; div_hi = 3'd0;
      len = 0;
      do begin @(negedge clk); len++; end while (!ref_tick);
      check(len == 41, "R8 old period kept", len, 41);
      len = 0;
      do begin @(negedge clk); len++; end while (!ref_tick);
      check(len == 10, "R8 new period", len, 10);
    end

    // R9: disable holds output low, no tick
    @(posedge clk); #1 div_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i > 0) check(ref_clk == 1'b0, "R9 disabled clk", int'(ref_clk), 0);
      check(ref_tick == 1'b0, "R9 disabled tick", int'(ref_tick), 0);
    end
    begin
      int len;
      @(posedge clk); #1 div_en = 1'b1;
      len = 0;
      do begin @(negedge clk); len++; end while (!ref_tick);
      check(len == 10, "R9 re-enable tick", len, 10);
    end

    // R10: source routing
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      @(posedge clk); #1 src_sel = 2'(s);
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (s == 0) check(ref_clk == clk_periph, "R10 periph", int'(ref_clk), int'(clk_periph));
        else        check(ref_clk == clk_ext, "R10 ext", int'(ref_clk), int'(clk_ext));
        check(ref_tick == 1'b0, "R10 no tick", int'(ref_tick), 0);
      end
    end
    @(posedge clk); #1 src_sel = 2'b01;
    measure(10, "R10 back to div");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule